// File: doc/BRIEF.md
# Multimode Up/Down Timer

A counter of `CNT_W` bits that steps up or down once per prescaler tick. A small write port sets a control byte, two load/capture registers, a compare register, the prescaler divider and a command bit. One decoded mode chosen from the control bits governs what happens when the count reaches its terminal value:

- **Free-running:** the count wraps silently.
- **Reload:** the count reloads from register 0.
- **Bi-load:** the count reloads alternately from register 0 and register 1.

Register 0 can also latch the count when a capture strobe arrives. Register 1 can track the live count so that it is readable while the counter runs. Three sources can clear the counter and restart the prescaler: a capture, a compare match, or a direct command.

The block outputs the live count, the three register contents and three single-clock event flags: end of count, capture and compare match. The capture strobe `cap_i` is taken to be synchronous to `clk_i` already.

Top module: `mm_timer`

## Requirements
- R1: After reset, the count, register 0, register 1 and the compare register read zero, and all three event flags are low.
- R2: Write port map (address on `wr_addr_i`):
  - Address 0 is the control byte, with these bits: 0 run, 1 count down, 2 bi-value, 3 register 0 captures, 4 register 1 holds, 5 continuous, 6 clear on capture, 7 clear on compare.
  - Address 1 is register 0, address 2 is register 1, address 3 is the compare register, address 4 is the prescaler divider `d`, and address 5 bit 0 issues a direct clear.
  - While run is set, the counter steps by one every `d+1` clocks, upward or downward as bit 1 selects.
- R3: The counter is free-running when bit 3 is set together with bit 2 or bit 5. In that case it wraps through all-ones or zero, never reloads and raises no end-of-count flag.
- R4: In any other mode, a tick that brings the count to all-ones (up) or zero (down) raises `eoc_o` for one clock. The next tick then loads the reload value.
  - The reload value is register 0 when bit 3 is clear.
  - The reload value is the clear value when bit 3 is set.
- R5: With bit 2 set and bit 3 clear (bi-load), successive reloads come from register 0, register 1, register 0, and so on.
- R6: While bit 2 is clear, the alternation returns to register 0, so the first reload after bi-value is enabled again always comes from register 0.
- R7: With bits 2 and 4 both clear, register 1 equals the live count on every clock. Otherwise it keeps the last value written to it.
- R8: When `cap_i` is high and bit 3 is set, register 0 takes the count held on that clock, and `cap_evt_o` is high for the following clock. When bit 3 is clear, `cap_i` has no effect.
- R9: A clear sets the count to zero when counting up and to all-ones when counting down. A direct clear takes precedence over a tick on the same clock.
- R10: With bits 3 and 6 set, each capture also clears the counter and restarts the prescaler.
- R11: A tick that brings the count equal to the compare register raises `cmp_evt_o` for one clock. With bit 7 set, the counter is then cleared on the next clock and the prescaler restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| cap_i | input | 1 | Synchronous capture strobe |
| count_o | output | CNT_W | Live count |
| reg0_o | output | CNT_W | Register 0 (reload or capture) |
| reg1_o | output | CNT_W | Register 1 (reload, hold or monitor) |
| cmp_o | output | CNT_W | Compare register |
| eoc_o | output | 1 | End-of-count pulse |
| cap_evt_o | output | 1 | Capture pulse |
| cmp_evt_o | output | 1 | Compare-match pulse |

## Verification
The bench builds the timer with `CNT_W=8` and `PRESC_W=4`. At that width a full wrap takes only 256 ticks, so every vector can reach wraparound, end-of-count reloads and several alternating bi-load reloads within a few hundred clocks. The four-bit divider is large enough to show a tick every fourth clock and to expose whether a capture clear restarts the prescaler.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;
  // control byte, bit 0 = run ... bit 7 = clear on compare
  typedef struct packed {
    logic clr_on_cmp;
    logic clr_on_cap;
    logic cont;
    logic r1_hold;
    logic r0_cap;
    logic bival;
    logic dir_down;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_REG0  = 3'd1;
  localparam logic [2:0] ADDR_REG1  = 3'd2;
  localparam logic [2:0] ADDR_CMP   = 3'd3;
  localparam logic [2:0] ADDR_PRESC = 3'd4;
  localparam logic [2:0] ADDR_CMD   = 3'd5;
endpackage

// File: rtl/mm_timer_presc.sv
module mm_timer_presc #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/mm_timer_regs.sv
module mm_timer_regs
  import mm_timer_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          cap_i,
  input  logic [W-1:0]  count_q_i,
  input  logic [W-1:0]  count_d_i,
  output ctrl_t         ctrl_o,
  output logic [W-1:0]  reg0_o,
  output logic [W-1:0]  reg1_o,
  output logic [W-1:0]  cmp_o,
  output logic [PW-1:0] div_o,
  output logic          cmd_clr_o,
  output logic          cap_hit_o,
  output logic          monitor_o,
  output logic          cap_evt_o
);
  ctrl_t         ctrl_q;
  logic [W-1:0]  reg0_q, reg1_q, cmp_q;
  logic [PW-1:0] div_q;
  logic          cap_evt_q;
  logic [4:0]    wr_sel;

  always_comb begin
    wr_sel    = '0;
    wr_sel[0] = wr_en_i & (wr_addr_i == ADDR_CTRL);
    wr_sel[1] = wr_en_i & (wr_addr_i == ADDR_REG0);
    wr_sel[2] = wr_en_i & (wr_addr_i == ADDR_REG1);
    wr_sel[3] = wr_en_i & (wr_addr_i == ADDR_CMP);
    wr_sel[4] = wr_en_i & (wr_addr_i == ADDR_PRESC);
  end

  assign cmd_clr_o = wr_en_i & (wr_addr_i == ADDR_CMD) & wr_data_i[0];
  assign cap_hit_o = cap_i & ctrl_q.r0_cap;
  assign monitor_o = ~ctrl_q.bival & ~ctrl_q.r1_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      reg0_q    <= '0;
      reg1_q    <= '0;
      cmp_q     <= '0;
      div_q     <= '0;
      cap_evt_q <= 1'b0;
    end else begin
      if (wr_sel[0]) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      // capture outranks a software write
      if (cap_hit_o)      reg0_q <= count_q_i;
      else if (wr_sel[1]) reg0_q <= wr_data_i;
      // monitor copies next count so reg1 and count update together
      if (monitor_o)      reg1_q <= count_d_i;
      else if (wr_sel[2]) reg1_q <= wr_data_i;
      if (wr_sel[3]) cmp_q <= wr_data_i;
      if (wr_sel[4]) div_q <= wr_data_i[PW-1:0];
      cap_evt_q <= cap_hit_o;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign reg0_o    = reg0_q;
  assign reg1_o    = reg1_q;
  assign cmp_o     = cmp_q;
  assign div_o     = div_q;
  assign cap_evt_o = cap_evt_q;
endmodule

// File: rtl/mm_timer_core.sv
module mm_timer_core
  import mm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  ctrl_t        ctrl_i,
  input  logic [W-1:0] reg0_i,
  input  logic [W-1:0] reg1_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] count_d_o,
  output logic         eoc_o,
  output logic         cmp_evt_o,
  output logic         free_run_o
);
  localparam logic [W-1:0] ALL0 = '0;
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt_q, cnt_d, term, clr_val, reload_val;
  logic         sel_q, bi_load, load, eoc_q, cmp_q;

  assign term       = ctrl_i.dir_down ? ALL0 : ALL1;
  assign clr_val    = ctrl_i.dir_down ? ALL1 : ALL0;
  assign free_run_o = ctrl_i.r0_cap & (ctrl_i.bival | ctrl_i.cont);
  assign bi_load    = ctrl_i.bival & ~ctrl_i.r0_cap;

  always_comb begin
    if (bi_load)             reload_val = sel_q ? reg1_i : reg0_i;
    else if (!ctrl_i.r0_cap) reload_val = reg0_i;
    else                     reload_val = clr_val;
  end

  always_comb begin
    cnt_d = cnt_q;
    load  = 1'b0;
    if (clr_i) begin
      cnt_d = clr_val;
    end else if (tick_i) begin
      if ((cnt_q == term) && !free_run_o) begin
        cnt_d = reload_val;
        load  = 1'b1;
      end else begin
        cnt_d = ctrl_i.dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      eoc_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (!ctrl_i.bival)        sel_q <= 1'b0;
      else if (load && bi_load) sel_q <= ~sel_q;
      eoc_q <= tick_i & ~clr_i & ~free_run_o & (cnt_d == term);
      cmp_q <= tick_i & ~clr_i & (cnt_d == cmp_i);
    end
  end

  assign count_o   = cnt_q;
  assign count_d_o = cnt_d;
  assign eoc_o     = eoc_q;
  assign cmp_evt_o = cmp_q;
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mm_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reg0_o,
  output logic [CNT_W-1:0] reg1_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             eoc_o,
  output logic             cap_evt_o,
  output logic             cmp_evt_o
);
  ctrl_t              ctrl;
  logic [PRESC_W-1:0] div;
  logic [CNT_W-1:0]   count_d;
  logic               tick, clr, cmd_clr, cap_hit, monitor, free_run;

  // any clear source also restarts the prescaler
  assign clr = cmd_clr | (cap_hit & ctrl.clr_on_cap) | (cmp_evt_o & ctrl.clr_on_cmp);

  mm_timer_regs #(.W(CNT_W), .PW(PRESC_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cap_i     (cap_i),
    .count_q_i (count_o),
    .count_d_i (count_d),
    .ctrl_o    (ctrl),
    .reg0_o    (reg0_o),
    .reg1_o    (reg1_o),
    .cmp_o     (cmp_o),
    .div_o     (div),
    .cmd_clr_o (cmd_clr),
    .cap_hit_o (cap_hit),
    .monitor_o (monitor),
    .cap_evt_o (cap_evt_o)
  );

  mm_timer_presc #(.PW(PRESC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl.run),
    .restart_i (clr),
    .div_i     (div),
    .tick_o    (tick)
  );

  mm_timer_core #(.W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .clr_i      (clr),
    .ctrl_i     (ctrl),
    .reg0_i     (reg0_o),
    .reg1_i     (reg1_o),
    .cmp_i      (cmp_o),
    .count_o    (count_o),
    .count_d_o  (count_d),
    .eoc_o      (eoc_o),
    .cmp_evt_o  (cmp_evt_o),
    .free_run_o (free_run)
  );
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cap_hit_i,
  input logic         monitor_i,
  input logic         free_run_i,
  input logic         clr_i,
  input logic         dir_down_i,
  input logic [W-1:0] count_i,
  input logic [W-1:0] reg0_i,
  input logic [W-1:0] reg1_i,
  input logic [W-1:0] cmp_i,
  input logic         eoc_i,
  input logic         cap_evt_i,
  input logic         cmp_evt_i
);
  localparam logic [W-1:0] ALL0 = '0;
  localparam logic [W-1:0] ALL1 = '1;

  a_r3_no_eoc_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_run_i |=> !eoc_i);

  a_r4_eoc_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |-> (count_i == ALL0 || count_i == ALL1));

  a_r7_monitor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    monitor_i |=> reg1_i == count_i);

  a_r8_capture_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit_i |=> (reg0_i == $past(count_i)) && cap_evt_i);

  a_r9_clear_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_i == ($past(dir_down_i) ? ALL1 : ALL0));

  a_r11_cmp_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_i |-> count_i == $past(cmp_i));
endmodule

bind mm_timer mm_timer_chk #(.W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_hit_i  (cap_hit),
  .monitor_i  (monitor),
  .free_run_i (free_run),
  .clr_i      (clr),
  .dir_down_i (ctrl.dir_down),
  .count_i    (count_o),
  .reg0_i     (reg0_o),
  .reg1_i     (reg1_o),
  .cmp_i      (cmp_o),
  .eoc_i      (eoc_o),
  .cap_evt_i  (cap_evt_o),
  .cmp_evt_i  (cmp_evt_o)
);

// File: tb/tb_mm_timer.sv
module tb_mm_timer;
  localparam int W  = 8;
  localparam int PW = 4;

  localparam logic [7:0] RUN = 8'h01, DOWN = 8'h02, BIV = 8'h04, R0C = 8'h08;
  localparam logic [7:0] R1H = 8'h10, CONT = 8'h20, CCAP = 8'h40, CCMP = 8'h80;

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  cfg;
    logic [7:0]  r0;
    logic [7:0]  r1;
    logic [7:0]  cmp;
    logic [3:0]  div;
    logic [15:0] n;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  8'h28, 8'h00, 8'h00, 8'h00, 4'd0, 16'd10,  8'h0A}, // R2 up count
    '{4'd3,  8'h28, 8'h00, 8'h00, 8'h00, 4'd0, 16'd260, 8'h04}, // R3 wrap
    '{4'd9,  8'h2A, 8'h00, 8'h00, 8'h00, 4'd0, 16'd3,   8'hFC}, // R9 down from all-ones
    '{4'd4,  8'h00, 8'hF0, 8'h00, 8'h00, 4'd0, 16'd258, 8'hF2}, // R4 reload up
    '{4'd4,  8'h02, 8'h10, 8'h00, 8'h00, 4'd0, 16'd258, 8'h0E}, // R4 reload down
    '{4'd5,  8'h04, 8'hFC, 8'hF0, 8'h00, 4'd0, 16'd262, 8'hF2}, // R5 second reload from reg1
    '{4'd2,  8'h28, 8'h00, 8'h00, 8'h00, 4'd3, 16'd20,  8'h05}, // R2 divider
    '{4'd5,  8'h04, 8'hFC, 8'hF0, 8'h00, 4'd0, 16'd277, 8'hFD}, // R5 third reload from reg0
    '{4'd11, 8'h80, 8'h00, 8'h00, 8'h05, 4'd0, 16'd20,  8'h02}, // R11 clear on compare up
    '{4'd3,  8'h0C, 8'h00, 8'h00, 8'h00, 4'd0, 16'd260, 8'h04}, // R3 bi-capture free-run
    '{4'd11, 8'h82, 8'h00, 8'h00, 8'hF9, 4'd0, 16'd16,  8'hFD}  // R11 clear on compare down
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          cap = 1'b0;
  logic [W-1:0]  count, reg0, reg1, cmp;
  logic          eoc, cap_evt, cmp_evt;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  mm_timer #(.CNT_W(W), .PRESC_W(PW)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .cap_i     (cap),
    .count_o   (count),
    .reg0_o    (reg0),
    .reg1_o    (reg1),
    .cmp_o     (cmp),
    .eoc_o     (eoc),
    .cap_evt_o (cap_evt),
    .cmp_evt_o (cmp_evt)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start(input logic [7:0] cfg, input logic [7:0] r0, input logic [7:0] r1,
                       input logic [7:0] c, input logic [3:0] dv);
    wr(3'd0, cfg);
    wr(3'd1, r0);
    wr(3'd2, r1);
    wr(3'd3, c);
    wr(3'd4, {4'h0, dv});
    wr(3'd5, 8'h01);
    wr(3'd0, cfg | RUN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int eoc_cnt;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", count, 8'h00);
    chk("R1 reg0", reg0, 8'h00);
    chk("R1 reg1", reg1, 8'h00);
    chk("R1 cmp", cmp, 8'h00);
    chk("R1 flags", {5'd0, eoc, cap_evt, cmp_evt}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      start(VECS[i].cfg, VECS[i].r0, VECS[i].r1, VECS[i].cmp, VECS[i].div);
      repeat (int'(VECS[i].n)) @(negedge clk);
      if (VECS[i].exp !== count)
        $display("  vector %0d tag R%0d", i, VECS[i].req);
      chk("vector", count, VECS[i].exp);
    end

    // R4 end-of-count pulse and reload
    start(8'h00, 8'hF0, 8'h00, 8'h00, 4'd0);
    repeat (255) @(negedge clk);
    chk("R4 at terminal", count, 8'hFF);
    chk("R4 eoc high", {7'd0, eoc}, 8'h01);
    @(negedge clk);
    chk("R4 reloaded", count, 8'hF0);
    chk("R4 eoc one clock", {7'd0, eoc}, 8'h00);

    // R3 no end-of-count while free-running
    start(R0C | CONT, 8'h00, 8'h00, 8'h00, 4'd0);
    eoc_cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (eoc) eoc_cnt++;
    end
    chk("R3 no eoc", eoc_cnt[7:0], 8'h00);

    // R9 direct clear beats tick, up then down
    start(R0C | CONT, 8'h00, 8'h00, 8'h00, 4'd0);
    repeat (5) @(negedge clk);
    wr(3'd5, 8'h01);
    chk("R9 clear up", count, 8'h00);
    @(negedge clk);
    chk("R9 resume", count, 8'h01);
    start(R0C | CONT | DOWN, 8'h00, 8'h00, 8'h00, 4'd0);
    repeat (5) @(negedge clk);
    wr(3'd5, 8'h01);
    chk("R9 clear down", count, 8'hFF);

    // R8 capture latch and pulse
    start(R0C | CONT, 8'h00, 8'h00, 8'h00, 4'd0);
    repeat (7) @(negedge clk);
    cap = 1'b1;
    @(negedge clk);
    cap = 1'b0;
    chk("R8 captured", reg0, 8'h07);
    chk("R8 cap_evt", {7'd0, cap_evt}, 8'h01);
    @(negedge clk);
    chk("R8 cap_evt one clock", {7'd0, cap_evt}, 8'h00);

    // R8 capture ignored when reg0 is a reload register
    start(8'h00, 8'h33, 8'h00, 8'h00, 4'd0);
    repeat (4) @(negedge clk);
    cap = 1'b1;
    @(negedge clk);
    cap = 1'b0;
    chk("R8 ignored reg0", reg0, 8'h33);
    chk("R8 ignored evt", {7'd0, cap_evt}, 8'h00);

    // R10 clear on capture restarts prescaler (divider 1)
    start(R0C | CONT | CCAP, 8'h00, 8'h00, 8'h00, 4'd1);
    repeat (10) @(negedge clk);
    v = count;
    cap = 1'b1;
    @(negedge clk);
    cap = 1'b0;
    chk("R10 captured", reg0, v);
    chk("R10 cleared", count, 8'h00);
    @(negedge clk);
    chk("R10 prescaler restarted", count, 8'h00);
    @(negedge clk);
    chk("R10 next tick", count, 8'h01);

    // R11 compare pulse without clear
    start(8'h00, 8'h00, 8'h00, 8'h20, 4'd0);
    repeat (32) @(negedge clk);
    chk("R11 match count", count, 8'h20);
    chk("R11 cmp_evt", {7'd0, cmp_evt}, 8'h01);
    @(negedge clk);
    chk("R11 no clear", count, 8'h21);
    chk("R11 cmp_evt one clock", {7'd0, cmp_evt}, 8'h00);

    // R7 monitor and hold
    start(R0C | CONT, 8'h00, 8'h00, 8'h00, 4'd0);
    repeat (9) @(negedge clk);
    chk("R7 monitor", reg1, count);
    start(R0C | CONT | R1H, 8'h00, 8'h55, 8'h00, 4'd0);
    repeat (9) @(negedge clk);
    chk("R7 hold", reg1, 8'h55);

    // R6 alternation restarts at reg0 after bi-value toggles off and on
    start(BIV, 8'hFC, 8'hF0, 8'h00, 4'd0);
    repeat (257) @(negedge clk);
    chk("R6 first reload", count, 8'hFD);
    wr(3'd0, RUN);
    wr(3'd0, BIV | RUN);
    wr(3'd5, 8'h01);
    repeat (256) @(negedge clk);
    chk("R6 reload from reg0", count, 8'hFC);

    finish_run();
  end
endmodule